// File: doc/BRIEF.md
# Memory Ordering Fence Controller

This block sits between an in-order issue stage and a memory interface that can keep several operations in flight at once. It keeps one outstanding-operation counter for each of four access classes (write, read, device output, device input). Issue-side requests are either memory operations of one class, or fences that carry a predecessor class mask and a successor class mask. The block answers each request with a single ready signal, and the issue stage advances only on a cycle where valid and ready are both high. Completions come back as one strobe per class.

A fence whose predecessor classes still have traffic in flight arms an ordering gate. While the gate is armed, operations of the successor classes are held. Operations outside the successor set still flow. Memory operations may also carry an acquire flag, a release flag or both. A release-marked operation waits until every class has drained. After an acquire-marked operation issues, every later request waits until that operation's class has drained.

Top module: `mem_order_gate`

## Requirements
- R1: Accepting an operation of class c adds one to that class's counter. A completion strobe on class c subtracts one. Both in the same cycle leave the counter unchanged. `busy[c]` is high exactly when the counter is nonzero, and it is updated at the same clock edge as the counter.
- R2: Class codes on `req_class` are 0 write, 1 read, 2 device output, 3 device input. Bit i of every class mask (`req_pred`, `req_succ`, `cpl_valid`, `busy`) stands for class code i, so bit 3 is input, bit 2 output, bit 1 read and bit 0 write.
- R3: An operation whose class counter holds its maximum value, 2**CNT_W-1, is not ready.
- R4: A completion strobe on a class whose counter is zero has no effect. The counter stays zero.
- R5: A fence with an empty predecessor mask, an empty successor mask, or no predecessor class busy is accepted and arms no gate. `gate_pending` stays low and later operations are not held.
- R6: After a fence is accepted with a busy predecessor class and a nonempty successor mask, operations of successor classes are not ready while any predecessor class is busy. Operations of other classes stay ready.
- R7: `gate_pending` rises on the edge that accepts a gate-arming fence and falls one edge after the last predecessor class drains. While it is high, a further fence is not ready.
- R8: Once an acquire-marked operation is accepted, no request of any kind is ready until that operation's class counter returns to zero.
- R9: A release-marked operation is not ready while any class is busy.
- R10: An operation marked both acquire and release waits for all classes to drain before issue, and then blocks later requests until its own class drains.
- R11: Synchronous reset clears all counters, the gate and the acquire hold. Afterwards `busy` is 0, `gate_pending` is 0 and a plain operation is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present at the issue head |
| req_fence | input | 1 | Request is a fence, not a memory operation |
| req_class | input | 2 | Class code of a memory operation |
| req_aq | input | 1 | Acquire flag of a memory operation |
| req_rl | input | 1 | Release flag of a memory operation |
| req_pred | input | 4 | Fence predecessor class mask |
| req_succ | input | 4 | Fence successor class mask |
| req_ready | output | 1 | Request may issue this cycle |
| cpl_valid | input | 4 | One completion strobe per class |
| busy | output | 4 | Registered per-class nonzero-counter flags |
| gate_pending | output | 1 | A fence gate is armed |

## Verification
The assertions check on every cycle that the counters step correctly and never overflow, that `busy` tracks its counter, and that an idle class ignores completions. They also check that a release never issues into traffic, that nothing issues on the cycle after an acquire, and that a second fence is held while a gate is armed. Some behaviour needs a specific history to show, and only the bench's scenarios cover it. That includes a gate letting non-successor traffic pass while it holds successor traffic, the gate clearing exactly after the last predecessor completion, the empty-mask fences, the acquire hold lasting until its class drains, and reset clearing an armed gate.

// File: rtl/mo_pkg.sv
package mo_pkg;
  localparam int NCLS = 4;

  typedef enum logic [1:0] {
    CLS_WRITE = 2'd0,
    CLS_READ  = 2'd1,
    CLS_OUT   = 2'd2,
    CLS_IN    = 2'd3
  } cls_e;

  typedef logic [NCLS-1:0] cls_mask_t;
endpackage

// File: rtl/mo_class_counter.sv
module mo_class_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             busy,
  output logic             full
);
  localparam logic [CNT_W-1:0] MAX_CNT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             busy_q;
  logic             dec_ok;

  // a completion on an empty class is dropped
  assign dec_ok = dec && (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (inc && !dec_ok)      cnt_d = cnt_q + 1'b1;
    else if (!inc && dec_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= (cnt_d != '0);
    end
  end

  assign cnt  = cnt_q;
  assign busy = busy_q;
  assign full = (cnt_q == MAX_CNT);
endmodule

// File: rtl/mo_fence_gate.sv
module mo_fence_gate
  import mo_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      fence_fire,
  input  cls_mask_t pred,
  input  cls_mask_t succ,
  input  cls_mask_t busy,
  output logic      active,
  output cls_mask_t hold_mask
);
  logic      active_q;
  cls_mask_t pred_q;
  cls_mask_t succ_q;
  logic      waiting;
  logic      arm;

  assign waiting = |(pred_q & busy);
  assign arm     = fence_fire && (|(pred & busy)) && (|succ);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      pred_q   <= '0;
      succ_q   <= '0;
    end else if (arm) begin
      active_q <= 1'b1;
      pred_q   <= pred;
      succ_q   <= succ;
    end else if (active_q && !waiting) begin
      active_q <= 1'b0;
      pred_q   <= '0;
      succ_q   <= '0;
    end
  end

  assign active    = active_q;
  assign hold_mask = (active_q && waiting) ? succ_q : '0;
endmodule

// File: rtl/mo_acq_track.sv
module mo_acq_track
  import mo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       acq_fire,
  input  logic [1:0] acq_cls,
  input  cls_mask_t  busy,
  output logic       block
);
  logic       active_q;
  logic [1:0] cls_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cls_q    <= 2'd0;
    end else if (acq_fire) begin
      active_q <= 1'b1;
      cls_q    <= acq_cls;
    end else if (active_q && !busy[cls_q]) begin
      active_q <= 1'b0;
    end
  end

  assign block = active_q && busy[cls_q];
endmodule

// File: rtl/mem_order_gate.sv
module mem_order_gate
  import mo_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_fence,
  input  logic [1:0] req_class,
  input  logic       req_aq,
  input  logic       req_rl,
  input  logic [3:0] req_pred,
  input  logic [3:0] req_succ,
  output logic       req_ready,
  input  logic [3:0] cpl_valid,
  output logic [3:0] busy,
  output logic       gate_pending
);
  cls_mask_t                   busy_w;
  cls_mask_t                   full_w;
  cls_mask_t                   inc_w;
  cls_mask_t                   hold_w;
  logic [NCLS-1:0][CNT_W-1:0]  cnt_all;
  logic                        acq_block;
  logic                        gate_act;
  logic                        op_ok;
  logic                        fence_ok;
  logic                        op_fire;
  logic                        fence_fire;

  generate
    for (genvar c = 0; c < NCLS; c++) begin : g_cls
      assign inc_w[c] = op_fire && (req_class == c[1:0]);
      mo_class_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .inc  (inc_w[c]),
        .dec  (cpl_valid[c]),
        .cnt  (cnt_all[c]),
        .busy (busy_w[c]),
        .full (full_w[c])
      );
    end
  endgenerate

  mo_fence_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .fence_fire (fence_fire),
    .pred       (req_pred),
    .succ       (req_succ),
    .busy       (busy_w),
    .active     (gate_act),
    .hold_mask  (hold_w)
  );

  mo_acq_track u_acq (
    .clk      (clk),
    .rst      (rst),
    .acq_fire (op_fire && req_aq),
    .acq_cls  (req_class),
    .busy     (busy_w),
    .block    (acq_block)
  );

  always_comb begin
    op_ok = !acq_block
            && !hold_w[req_class]
            && !full_w[req_class]
            && !(req_rl && (|busy_w));
    fence_ok = !acq_block && !gate_act;
  end

  assign req_ready    = req_fence ? fence_ok : op_ok;
  assign op_fire      = req_valid && !req_fence && op_ok;
  assign fence_fire   = req_valid && req_fence && fence_ok;
  assign busy         = busy_w;
  assign gate_pending = gate_act;
endmodule

// File: rtl/mo_order_checker.sv
module mo_order_checker #(
  parameter int CNT_W = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic                  req_fence,
  input logic [1:0]            req_class,
  input logic                  req_aq,
  input logic                  req_rl,
  input logic                  req_ready,
  input logic [3:0]            cpl_valid,
  input logic [3:0]            busy,
  input logic                  gate_pending,
  input logic [3:0][CNT_W-1:0] cnt_all
);
  localparam logic [CNT_W-1:0] MAX_CNT = {CNT_W{1'b1}};

  logic op_take;
  assign op_take = req_valid && req_ready && !req_fence;

  generate
    for (genvar c = 0; c < 4; c++) begin : g_chk
      logic take_c;
      assign take_c = op_take && (req_class == c[1:0]);

      // R1: issue without completion raises the count by one
      p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        (take_c && !cpl_valid[c]) |=> (cnt_all[c] == $past(cnt_all[c]) + 1'b1));

      // R1: busy flag agrees with the counter
      p_busy_track_r1: assert property (@(posedge clk) disable iff (rst)
        busy[c] == (cnt_all[c] != '0));

      // R3: a saturated class never accepts another operation
      p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt_all[c] == MAX_CNT) |-> !take_c);

      // R4: an idle class stays idle without an issue
      p_idle_cpl_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt_all[c] == '0 && !take_c) |=> (cnt_all[c] == '0));
    end
  endgenerate

  // R9: release never issues into outstanding traffic
  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_fence && req_rl && (|busy)) |-> !req_ready);

  // R8: nothing issues on the cycle after an acquire
  p_acquire_r8: assert property (@(posedge clk) disable iff (rst)
    (op_take && req_aq) |=> !(req_valid && req_ready));

  // R7: a second fence waits while a gate is armed
  p_gate_fence_r7: assert property (@(posedge clk) disable iff (rst)
    (gate_pending && req_valid && req_fence) |-> !req_ready);
endmodule

bind mem_order_gate mo_order_checker #(.CNT_W(CNT_W)) u_order_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_fence    (req_fence),
  .req_class    (req_class),
  .req_aq       (req_aq),
  .req_rl       (req_rl),
  .req_ready    (req_ready),
  .cpl_valid    (cpl_valid),
  .busy         (busy),
  .gate_pending (gate_pending),
  .cnt_all      (cnt_all)
);

// File: tb/test_mem_order_gate.sv
module test_mem_order_gate;
  localparam int CNT_W = 4;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_fence = 1'b0;
  logic [1:0] req_class = 2'd0;
  logic       req_aq = 1'b0;
  logic       req_rl = 1'b0;
  logic [3:0] req_pred = 4'h0;
  logic [3:0] req_succ = 4'h0;
  logic [3:0] cpl_valid = 4'h0;
  logic       req_ready;
  logic [3:0] busy;
  logic       gate_pending;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  mem_order_gate #(.CNT_W(CNT_W)) i_mem_order_gate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_fence(req_fence),
    .req_class(req_class), .req_aq(req_aq), .req_rl(req_rl),
    .req_pred(req_pred), .req_succ(req_succ), .req_ready(req_ready),
    .cpl_valid(cpl_valid), .busy(busy), .gate_pending(gate_pending)
  );

  typedef struct packed {
    logic       v;
    logic       f;
    logic [1:0] cls;
    logic       aq;
    logic       rl;
    logic [3:0] pred;
    logic [3:0] succ;
    logic [3:0] cpl;
    logic       rdy;
    logic [3:0] bsy;
    logic       gt;
    logic [3:0] rq;
  } vec_t;

  localparam logic       T = 1'b1;
  localparam logic       F = 1'b0;
  localparam logic [1:0] CW = 2'd0;  // write
  localparam logic [1:0] CR = 2'd1;  // read
  localparam logic [1:0] CO = 2'd2;  // output
  localparam logic [1:0] CI = 2'd3;  // input
  localparam int NV = 31;

  // fields: v f cls aq rl pred succ cpl | exp ready, exp busy, exp gate | req
  localparam vec_t VEC [NV] = '{
    '{F,F,CW,F,F,4'h0,4'h0,4'h0, T,4'h0,F, 4'd11}, // R11 idle after reset
    '{T,F,CW,F,F,4'h0,4'h0,4'h0, T,4'h0,F, 4'd1},  // R1 write issues
    '{T,F,CR,F,F,4'h0,4'h0,4'h0, T,4'h1,F, 4'd2},  // R2 read sets bit 1
    '{T,F,CW,F,F,4'h0,4'h0,4'h1, T,4'h3,F, 4'd1},  // R1 issue+complete same cycle
    '{T,F,CO,F,T,4'h0,4'h0,4'h0, F,4'h3,F, 4'd9},  // R9 release held
    '{T,T,CW,F,F,4'h1,4'h2,4'h0, T,4'h3,F, 4'd6},  // R6 fence w -> r arms
    '{T,F,CR,F,F,4'h0,4'h0,4'h0, F,4'h3,T, 4'd6},  // R6 read held
    '{T,F,CO,F,F,4'h0,4'h0,4'h0, T,4'h3,T, 4'd6},  // R6 output passes
    '{T,T,CW,F,F,4'hF,4'hF,4'h0, F,4'h7,T, 4'd7},  // R7 second fence held
    '{F,F,CW,F,F,4'h0,4'h0,4'h1, T,4'h7,T, 4'd6},  // R6 last write completes
    '{T,F,CR,F,F,4'h0,4'h0,4'h0, T,4'h6,T, 4'd7},  // R7 gate still flagged, read free
    '{F,F,CW,F,F,4'h0,4'h0,4'h6, T,4'h6,F, 4'd7},  // R7 gate dropped
    '{F,F,CW,F,F,4'h0,4'h0,4'h2, T,4'h2,F, 4'd1},  // R1 drain read
    '{T,F,CI,T,F,4'h0,4'h0,4'h0, T,4'h0,F, 4'd8},  // R8 acquire input
    '{T,F,CW,F,F,4'h0,4'h0,4'h0, F,4'h8,F, 4'd8},  // R8 write held
    '{T,T,CW,F,F,4'h0,4'h0,4'h0, F,4'h8,F, 4'd8},  // R8 fence held
    '{F,F,CW,F,F,4'h0,4'h0,4'h8, F,4'h8,F, 4'd8},  // R8 input completes
    '{T,F,CW,F,F,4'h0,4'h0,4'h0, T,4'h0,F, 4'd8},  // R8 hold released
    '{T,T,CW,F,F,4'h0,4'hF,4'h0, T,4'h1,F, 4'd5},  // R5 empty pred
    '{T,F,CW,F,F,4'h0,4'h0,4'h0, T,4'h1,F, 4'd5},  // R5 no gate
    '{T,T,CW,F,F,4'h1,4'h0,4'h0, T,4'h1,F, 4'd5},  // R5 empty succ
    '{T,F,CR,T,T,4'h0,4'h0,4'h0, F,4'h1,F, 4'd10}, // R10 aq+rl waits
    '{F,F,CW,F,F,4'h0,4'h0,4'h1, T,4'h1,F, 4'd5},  // R5 still no gate
    '{F,F,CW,F,F,4'h0,4'h0,4'h1, T,4'h1,F, 4'd1},  // R1 drain write
    '{T,F,CR,T,T,4'h0,4'h0,4'h0, T,4'h0,F, 4'd10}, // R10 issues when drained
    '{T,F,CW,F,F,4'h0,4'h0,4'h0, F,4'h2,F, 4'd10}, // R10 then blocks
    '{F,F,CW,F,F,4'h0,4'h0,4'h2, F,4'h2,F, 4'd10}, // R10 read completes
    '{F,F,CW,F,F,4'h0,4'h0,4'h2, T,4'h0,F, 4'd4},  // R4 completion on idle read
    '{T,F,CW,F,F,4'h0,4'h0,4'h0, T,4'h0,F, 4'd4},  // R4 read stayed zero
    '{F,F,CW,F,F,4'h0,4'h0,4'h1, T,4'h1,F, 4'd1},  // R1 drain
    '{F,F,CW,F,F,4'h0,4'h0,4'h0, T,4'h0,F, 4'd1}   // R1 all idle
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic v, input logic f, input logic [1:0] c,
                       input logic aq, input logic rl, input logic [3:0] p,
                       input logic [3:0] s, input logic [3:0] cp);
    @(negedge clk);
    req_valid = v; req_fence = f; req_class = c; req_aq = aq; req_rl = rl;
    req_pred = p; req_succ = s; cpl_valid = cp;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      string tg;
      drive(VEC[i].v, VEC[i].f, VEC[i].cls, VEC[i].aq, VEC[i].rl,
            VEC[i].pred, VEC[i].succ, VEC[i].cpl);
      tg = $sformatf("R%0d vec%0d", VEC[i].rq, i);
      chk({tg, " ready"}, {7'd0, req_ready}, {7'd0, VEC[i].rdy});
      chk({tg, " busy"},  {4'd0, busy},      {4'd0, VEC[i].bsy});
      chk({tg, " gate"},  {7'd0, gate_pending}, {7'd0, VEC[i].gt});
    end

    // R3: fill the write counter to its limit
    for (int k = 0; k < MAXC; k++) begin
      drive(T, F, CW, F, F, 4'h0, 4'h0, 4'h0);
      chk("R3 fill ready", {7'd0, req_ready}, 8'd1);
    end
    drive(T, F, CW, F, F, 4'h0, 4'h0, 4'h0);
    chk("R3 full write held", {7'd0, req_ready}, 8'd0);
    drive(T, F, CR, F, F, 4'h0, 4'h0, 4'h0);
    chk("R3 other class free", {7'd0, req_ready}, 8'd1);
    drive(F, F, CW, F, F, 4'h0, 4'h0, 4'h3);
    chk("R3 busy before drain", {4'd0, busy}, 8'h3);
    for (int k = 1; k < MAXC; k++) begin
      drive(F, F, CW, F, F, 4'h0, 4'h0, 4'h1);
    end
    drive(F, F, CW, F, F, 4'h0, 4'h0, 4'h0);
    chk("R3 drained", {4'd0, busy}, 8'h0);

    // R11: reset clears an armed gate and outstanding counts
    drive(T, F, CW, F, F, 4'h0, 4'h0, 4'h0);
    drive(T, T, CW, F, F, 4'h1, 4'h2, 4'h0);
    drive(F, F, CW, F, F, 4'h0, 4'h0, 4'h0);
    chk("R11 gate armed before reset", {7'd0, gate_pending}, 8'd1);
    rst = 1'b1;
    repeat (2) drive(F, F, CW, F, F, 4'h0, 4'h0, 4'h0);
    rst = 1'b0;
    drive(T, F, CR, F, F, 4'h0, 4'h0, 4'h0);
    chk("R11 busy cleared", {4'd0, busy}, 8'h0);
    chk("R11 gate cleared", {7'd0, gate_pending}, 8'd0);
    chk("R11 read ready", {7'd0, req_ready}, 8'd1);
    drive(F, F, CW, F, F, 4'h0, 4'h0, 4'h0);
    chk("R1 read counted after reset", {4'd0, busy}, 8'h2);

    finish_run();
  end
endmodule